// File: doc/BRIEF.md
# PCI Target Single-Read Controller

This block is the target side of a PCI memory read that has exactly one data phase. During the address phase it captures the address, the command and the 64-bit request. In the next clock it compares the captured address with a set of base address ranges. Each range is a parameter made of a base and a size mask with power-of-two alignment. When a range matches, the block claims the transaction on the PCI bus. It shows the captured command, the address and the matching range to a simple active-low local interface, and takes one data word from the local side through an acknowledge and ready handshake. It then places that word on AD together with TRDY#.

The sequence is a fixed pipeline:
- The local side sees the hit one cycle before DEVSEL# is asserted.
- A local transfer counts only when the acknowledge is low now and the ready was low at the previous edge.
- The word reaches AD one registered cycle after the transfer.

When no range matches, the block stays silent on both sides until the bus returns to idle.

Top module: `pci_tgt_rd`

## Requirements
- R1: While reset is active, every active-low output is high, `ad_oe_o` and `ctl_oe_o` are low, and `loc_sts_o` is zero.
- R2: An address phase is a sample with FRAME# low where the previous sample had FRAME# high. The transaction hits range i when (address & mask_i) == (base_i & mask_i) and the command on C/BE# is 4'b0110. On a hit, `loc_frame_no` goes low after the second edge counted from the address-phase edge.
- R3: While `loc_frame_no` is low, `loc_cmd_o` and `loc_adr_o` hold the captured command and address. In `loc_sts_o`, bit i is set for the matching range i, bits 6 to NUM_BAR are 0, bit 7 is set when REQ64# was low in the address phase, and bit 8 is set. Otherwise `loc_sts_o` is zero.
- R4: `ctl_oe_o` turns on in the same cycle as `loc_frame_no`, with DEVSEL#, ACK64#, TRDY# and STOP# still high. DEVSEL# goes low one cycle later. STOP# is never asserted.
- R5: ACK64# goes low together with DEVSEL# only when REQ64# was low in the address phase. Otherwise it stays high.
- R6: In the cycle in which DEVSEL# goes low, `loc_ack_no` goes low and `ad_oe_o` goes high.
- R7: `loc_xfr_no` is low in exactly the cycles in which `loc_ack_no` is low and `loc_rdy_ni` was sampled low at the previous edge. This happens once per transaction.
- R8: On the edge after the transfer cycle, `ad_o` takes the `loc_dat_i` value that was present in the transfer cycle. TRDY# goes low and `loc_ack_no` returns high at the same edge. Later changes on `loc_dat_i` do not alter `ad_o`.
- R9: At the first edge that samples both IRDY# and TRDY# low, the block releases the bus. TRDY#, DEVSEL# and ACK64# go high, `ad_oe_o` goes low, `loc_frame_no` goes high and `loc_sts_o` clears. `ctl_oe_o` drops one cycle later.
- R10: On a miss (no range matches, or a command other than 4'b0110), all PCI and local outputs keep their idle values. The block accepts a new address phase once FRAME# and IRDY# have both been sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | FRAME# from the master |
| irdy_ni | input | 1 | IRDY# from the master |
| req64_ni | input | 1 | REQ64# from the master |
| cbe_ni | input | 4 | C/BE# lines; carry the command in the address phase |
| ad_i | input | AW | AD bus input |
| ad_o | output | DW | AD bus output data |
| ad_oe_o | output | 1 | AD output enable |
| ctl_oe_o | output | 1 | Output enable for DEVSEL#, ACK64#, TRDY#, STOP# |
| devsel_no | output | 1 | DEVSEL# |
| ack64_no | output | 1 | ACK64# |
| trdy_no | output | 1 | TRDY# |
| stop_no | output | 1 | STOP# |
| loc_frame_no | output | 1 | Local transaction frame, active low |
| loc_sts_o | output | 9 | Local status: range hits, 64-bit flag (bit 7), busy (bit 8) |
| loc_cmd_o | output | 4 | Captured command |
| loc_adr_o | output | AW | Captured address |
| loc_ack_no | output | 1 | Local acknowledge, active low |
| loc_rdy_ni | input | 1 | Local ready, active low |
| loc_dat_i | input | DW | Local read data |
| loc_xfr_no | output | 1 | Local transfer strobe, active low |

## Verification
Timing is counted in edges from the address-phase edge A:
- The local frame and status are due after A+1.
- DEVSEL#, ACK64#, the local acknowledge and the AD enable are due after A+2.
- The transfer strobe is due after the first edge, from A+2 on, that samples ready low (call it X).
- TRDY# and the AD word are due after X+1.
- The release is due after the first edge, from X+2 on, that samples IRDY# low (call it D). The control enable drops after D+1.

The reference model in the bench records A, X and D from the sampled inputs alone. At every falling edge it derives the expected value of every output from those counts. Each output is therefore compared half a cycle after the edge that sets it. Ready is applied early, on time and late, and IRDY# is delayed by the master, so each window is tested at both of its ends.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEC, ST_CLAIM, ST_WAIT, ST_DRIVE, ST_TURN, ST_MISS
  } tgt_st_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam int STS_W    = 9;
  localparam int STS_W64  = 7;
  localparam int STS_BUSY = 8;
endpackage

// File: rtl/pci_bar_dec.sv
module pci_bar_dec #(
  parameter int                    NUM_BAR  = 2,
  parameter int                    AW       = 32,
  parameter logic [NUM_BAR*AW-1:0] BAR_BASE = '0,
  parameter logic [NUM_BAR*AW-1:0] BAR_MASK = '0
) (
  input  logic [AW-1:0]      adr_i,
  input  logic [3:0]         cmd_i,
  output logic [NUM_BAR-1:0] hit_o
);
  import pci_tgt_pkg::*;

  logic cmd_ok;
  assign cmd_ok = (cmd_i == CMD_MEM_RD);

  for (genvar g = 0; g < NUM_BAR; g++) begin : g_bar
    localparam logic [AW-1:0] BASE = BAR_BASE[g*AW +: AW];
    localparam logic [AW-1:0] MASK = BAR_MASK[g*AW +: AW];
    assign hit_o[g] = cmd_ok && ((adr_i & MASK) == (BASE & MASK));
  end
endmodule

// File: rtl/pci_loc_xfer.sv
module pci_loc_xfer #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          loc_rdy_ni,
  input  logic          loc_ack_ni,
  input  logic [DW-1:0] loc_dat_i,
  output logic          xfr_o,
  output logic [DW-1:0] ad_o
);
  logic          rdy_q;
  logic [DW-1:0] dat_q;

  // transfer: ack low now, ready low at previous edge
  assign xfr_o = !loc_ack_ni && rdy_q;
  assign ad_o  = dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      dat_q <= '0;
    end else begin
      rdy_q <= !loc_rdy_ni;
      if (xfr_o) dat_q <= loc_dat_i;
    end
  end
endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm #(
  parameter int NUM_BAR = 2,
  parameter int AW      = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_ni,
  input  logic               irdy_ni,
  input  logic               req64_ni,
  input  logic [3:0]         cbe_ni,
  input  logic [AW-1:0]      ad_i,
  input  logic [NUM_BAR-1:0] hit_i,
  input  logic               xfr_i,
  output logic [AW-1:0]      adr_o,
  output logic [3:0]         cmd_o,
  output logic               w64_o,
  output logic [NUM_BAR-1:0] hit_o,
  output logic               loc_frame_no,
  output logic               loc_ack_no,
  output logic               ctl_oe_o,
  output logic               ad_oe_o,
  output logic               devsel_no,
  output logic               ack64_no,
  output logic               trdy_no
);
  import pci_tgt_pkg::*;

  tgt_st_e st_q;
  logic    frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      frame_q      <= 1'b1;
      adr_o        <= '0;
      cmd_o        <= '0;
      w64_o        <= 1'b0;
      hit_o        <= '0;
      loc_frame_no <= 1'b1;
      loc_ack_no   <= 1'b1;
      ctl_oe_o     <= 1'b0;
      ad_oe_o      <= 1'b0;
      devsel_no    <= 1'b1;
      ack64_no     <= 1'b1;
      trdy_no      <= 1'b1;
    end else begin
      frame_q <= frame_ni;
      unique case (st_q)
        ST_IDLE: if (!frame_ni && frame_q) begin
          adr_o <= ad_i;
          cmd_o <= cbe_ni;
          w64_o <= !req64_ni;
          st_q  <= ST_DEC;
        end
        ST_DEC: if (|hit_i) begin
          hit_o        <= hit_i;
          loc_frame_no <= 1'b0;
          ctl_oe_o     <= 1'b1;
          st_q         <= ST_CLAIM;
        end else begin
          st_q <= ST_MISS;
        end
        ST_CLAIM: begin
          devsel_no  <= 1'b0;
          ack64_no   <= !w64_o;
          loc_ack_no <= 1'b0;
          ad_oe_o    <= 1'b1;
          st_q       <= ST_WAIT;
        end
        ST_WAIT: if (xfr_i) begin
          loc_ack_no <= 1'b1;
          trdy_no    <= 1'b0;
          st_q       <= ST_DRIVE;
        end
        ST_DRIVE: if (!irdy_ni) begin
          trdy_no      <= 1'b1;
          devsel_no    <= 1'b1;
          ack64_no     <= 1'b1;
          ad_oe_o      <= 1'b0;
          loc_frame_no <= 1'b1;
          hit_o        <= '0;
          st_q         <= ST_TURN;
        end
        ST_TURN: begin
          ctl_oe_o <= 1'b0;
          st_q     <= ST_IDLE;
        end
        ST_MISS: if (frame_ni && irdy_ni) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_tgt_rd.sv
module pci_tgt_rd #(
  parameter int                    NUM_BAR  = 2,
  parameter int                    AW       = 32,
  parameter int                    DW       = 32,
  parameter logic [NUM_BAR*AW-1:0] BAR_BASE = {32'h2000_0000, 32'h1000_0000},
  parameter logic [NUM_BAR*AW-1:0] BAR_MASK = {32'hFFFF_0000, 32'hFFFF_F000}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_ni,
  input  logic          irdy_ni,
  input  logic          req64_ni,
  input  logic [3:0]    cbe_ni,
  input  logic [AW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          ctl_oe_o,
  output logic          devsel_no,
  output logic          ack64_no,
  output logic          trdy_no,
  output logic          stop_no,
  output logic          loc_frame_no,
  output logic [8:0]    loc_sts_o,
  output logic [3:0]    loc_cmd_o,
  output logic [AW-1:0] loc_adr_o,
  output logic          loc_ack_no,
  input  logic          loc_rdy_ni,
  input  logic [DW-1:0] loc_dat_i,
  output logic          loc_xfr_no
);
  import pci_tgt_pkg::*;

  logic [NUM_BAR-1:0] hit_dec, hit_q;
  logic [AW-1:0]      adr_q;
  logic [3:0]         cmd_q;
  logic               w64_q, xfr;

  pci_bar_dec #(
    .NUM_BAR(NUM_BAR), .AW(AW), .BAR_BASE(BAR_BASE), .BAR_MASK(BAR_MASK)
  ) u_dec (
    .adr_i(adr_q), .cmd_i(cmd_q), .hit_o(hit_dec)
  );

  pci_tgt_fsm #(.NUM_BAR(NUM_BAR), .AW(AW)) u_fsm (
    .clk_i, .rst_ni, .frame_ni, .irdy_ni, .req64_ni, .cbe_ni, .ad_i,
    .hit_i(hit_dec), .xfr_i(xfr),
    .adr_o(adr_q), .cmd_o(cmd_q), .w64_o(w64_q), .hit_o(hit_q),
    .loc_frame_no, .loc_ack_no, .ctl_oe_o, .ad_oe_o,
    .devsel_no, .ack64_no, .trdy_no
  );

  pci_loc_xfer #(.DW(DW)) u_xfer (
    .clk_i, .rst_ni, .loc_rdy_ni, .loc_ack_ni(loc_ack_no), .loc_dat_i,
    .xfr_o(xfr), .ad_o
  );

  assign stop_no    = 1'b1;
  assign loc_xfr_no = !xfr;
  assign loc_cmd_o  = cmd_q;
  assign loc_adr_o  = adr_q;

  always_comb begin
    loc_sts_o                = '0;
    loc_sts_o[NUM_BAR-1:0]   = hit_q;
    loc_sts_o[STS_W64]       = w64_q && !loc_frame_no;
    loc_sts_o[STS_BUSY]      = !loc_frame_no;
  end
endmodule

// File: rtl/pci_tgt_rd_chk.sv
module pci_tgt_rd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic irdy_ni,
  input logic ad_oe_o,
  input logic ctl_oe_o,
  input logic devsel_no,
  input logic ack64_no,
  input logic trdy_no,
  input logic loc_frame_no,
  input logic loc_ack_no,
  input logic loc_rdy_ni,
  input logic loc_xfr_no
);
  p_oe_with_devsel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !devsel_no |-> ctl_oe_o);
  p_devsel_after_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(loc_frame_no) |=> !devsel_no);
  p_ack64_with_devsel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack64_no |-> !devsel_no);
  p_ack_with_ad_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loc_ack_no |-> (ad_oe_o && !devsel_no));
  p_xfr_qual_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loc_xfr_no |-> (!loc_ack_no && !$past(loc_rdy_ni)));
  p_xfr_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loc_xfr_no |=> loc_xfr_no);
  p_trdy_after_xfr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loc_xfr_no |=> (!trdy_no && loc_ack_no));
  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no && !irdy_ni) |=> (trdy_no && devsel_no && !ad_oe_o && loc_frame_no && ctl_oe_o));
  p_claim_needs_frame_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !devsel_no |-> !loc_frame_no);
endmodule

bind pci_tgt_rd pci_tgt_rd_chk u_chk (
  .clk_i, .rst_ni, .irdy_ni, .ad_oe_o, .ctl_oe_o, .devsel_no, .ack64_no,
  .trdy_no, .loc_frame_no, .loc_ack_no, .loc_rdy_ni, .loc_xfr_no
);

// File: tb/sim_pci_tgt_rd.sv
module sim_pci_tgt_rd;
  localparam logic [63:0] BASES = {32'h2000_0000, 32'h1000_0000};
  localparam logic [63:0] MASKS = {32'hFFFF_0000, 32'hFFFF_F000};
  localparam int BIG = 1000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, req64_n = 1'b1, loc_rdy_n = 1'b1;
  logic [3:0]  cbe = '0;
  logic [31:0] ad_in = '0, loc_dat = '0;
  logic [31:0] ad_out, loc_adr;
  logic [8:0]  loc_sts;
  logic [3:0]  loc_cmd;
  logic ad_oe, ctl_oe, devsel_n, ack64_n, trdy_n, stop_n, loc_frame_n, loc_ack_n, loc_xfr_n;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pci_tgt_rd #(.NUM_BAR(2), .AW(32), .DW(32), .BAR_BASE(BASES), .BAR_MASK(MASKS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .irdy_ni(irdy_n), .req64_ni(req64_n),
    .cbe_ni(cbe), .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe), .ctl_oe_o(ctl_oe),
    .devsel_no(devsel_n), .ack64_no(ack64_n), .trdy_no(trdy_n), .stop_no(stop_n),
    .loc_frame_no(loc_frame_n), .loc_sts_o(loc_sts), .loc_cmd_o(loc_cmd),
    .loc_adr_o(loc_adr), .loc_ack_no(loc_ack_n), .loc_rdy_ni(loc_rdy_n),
    .loc_dat_i(loc_dat), .loc_xfr_no(loc_xfr_n)
  );

  function automatic logic [1:0] bar_hit(input logic [31:0] a, input logic [3:0] c);
    logic [1:0] h;
    for (int i = 0; i < 2; i++)
      h[i] = (c == 4'b0110) && ((a & MASKS[i*32 +: 32]) == (BASES[i*32 +: 32] & MASKS[i*32 +: 32]));
    return h;
  endfunction

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  // reference model: timestamps of address phase, transfer and completion
  bit m_act = 0, m_w64 = 0, pf = 1;
  logic [1:0]  m_hit = '0;
  logic [31:0] m_adr = '0, m_dat = '0;
  logic [3:0]  m_cmd = '0;
  int age = 0, xa = BIG, da = BIG;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; pf = 1;
    end else begin
      if (!m_act) begin
        if (!frame_n && pf) begin
          m_act = 1; age = 0; xa = BIG; da = BIG;
          m_adr = ad_in; m_cmd = cbe; m_w64 = !req64_n; m_hit = bar_hit(ad_in, cbe);
        end
      end else begin
        age++;
        if (m_hit != 0) begin
          if (xa == BIG && age >= 2 && !loc_rdy_n) xa = age;
          if (age == xa + 1) m_dat = loc_dat;
          if (da == BIG && xa != BIG && age >= xa + 2 && !irdy_n) da = age;
          if (da != BIG && age == da + 1) m_act = 0;
        end else if (age >= 2 && frame_n && irdy_n) m_act = 0;
      end
      pf = frame_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit h, fr, oe, dv, ak, xf, tr;
      string tg;
      h  = m_act && (m_hit != 0);
      fr = h && age >= 1 && age < da;
      oe = h && age >= 1 && age <= da;
      dv = h && age >= 2 && age < da;
      ak = h && age >= 2 && age <= xa && age < da;
      xf = h && age == xa;
      tr = h && xa != BIG && age >= xa + 1 && age < da;
      tg = (m_act && m_hit == 0) ? "R10" : (h && da != BIG && age >= da) ? "R9" : "";
      chk(tg == "" ? "R2" : tg, "loc_frame_n", 32'(loc_frame_n), 32'(!fr));
      chk(tg == "" ? "R3" : tg, "loc_sts", 32'(loc_sts), fr ? 32'({1'b1, m_w64, 5'b0, m_hit}) : 32'd0);
      if (fr) begin
        chk("R3", "loc_cmd", 32'(loc_cmd), 32'(m_cmd));
        chk("R3", "loc_adr", loc_adr, m_adr);
      end
      chk(tg == "" ? "R4" : tg, "ctl_oe", 32'(ctl_oe), 32'(oe));
      chk(tg == "" ? "R4" : tg, "devsel_n", 32'(devsel_n), 32'(!dv));
      chk("R4", "stop_n", 32'(stop_n), 32'd1);
      chk(tg == "" ? "R5" : tg, "ack64_n", 32'(ack64_n), 32'(!(dv && m_w64)));
      chk(tg == "" ? "R6" : tg, "loc_ack_n", 32'(loc_ack_n), 32'(!ak));
      chk(tg == "" ? "R6" : tg, "ad_oe", 32'(ad_oe), 32'(dv));
      chk(tg == "" ? "R7" : tg, "loc_xfr_n", 32'(loc_xfr_n), 32'(!xf));
      chk(tg == "" ? "R8" : tg, "trdy_n", 32'(trdy_n), 32'(!tr));
      if (tr) chk("R8", "ad_out", ad_out, m_dat);
    end
  end

  task automatic txn(input logic [31:0] a, input logic [3:0] c, input bit r64,
                     input int rdy_at, input int irdy_dly, input logic [31:0] d);
    bit hit, seen_x, seen_t;
    hit = bar_hit(a, c) != 0;
    seen_x = 0; seen_t = 0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; req64_n = !r64; ad_in = a; cbe = c; loc_dat = d;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      frame_n = 1'b1; req64_n = 1'b1; ad_in = '0; cbe = '0;
      irdy_n = (k <= irdy_dly);
      if (!hit) begin
        if (k >= 4) begin irdy_n = 1'b1; break; end
      end else begin
        if (!loc_xfr_n) seen_x = 1;
        if (seen_t && trdy_n) begin irdy_n = 1'b1; break; end
        if (!trdy_n && !seen_t) begin seen_t = 1; loc_dat = ~d; end // R8: later data ignored
        loc_rdy_n = (k >= rdy_at && !seen_x) ? 1'b0 : 1'b1;
      end
    end
    irdy_n = 1'b1; loc_rdy_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "rst devsel_n", 32'(devsel_n), 32'd1);
    chk("R1", "rst trdy_n", 32'(trdy_n), 32'd1);
    chk("R1", "rst ack64_n", 32'(ack64_n), 32'd1);
    chk("R1", "rst stop_n", 32'(stop_n), 32'd1);
    chk("R1", "rst loc_frame_n", 32'(loc_frame_n), 32'd1);
    chk("R1", "rst loc_ack_n", 32'(loc_ack_n), 32'd1);
    chk("R1", "rst loc_xfr_n", 32'(loc_xfr_n), 32'd1);
    chk("R1", "rst oes", 32'({ad_oe, ctl_oe}), 32'd0);
    chk("R1", "rst loc_sts", 32'(loc_sts), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    txn(32'h1000_0040, 4'b0110, 1, 3, 0, 32'hCAFE_0001);  // R2 range 0, 64-bit
    txn(32'h2000_1234, 4'b0110, 0, 1, 0, 32'h1234_5678);  // R5 32-bit, early ready
    txn(32'h1000_0FFC, 4'b0110, 1, 6, 8, 32'hA5A5_5A5A);  // late ready, slow IRDY#
    txn(32'h3000_0000, 4'b0110, 1, 2, 0, 32'hDEAD_0000);  // R10 out of range
    txn(32'h1000_0100, 4'b0111, 0, 2, 0, 32'hDEAD_0001);  // R10 wrong command
    txn(32'h1000_1000, 4'b0110, 0, 2, 0, 32'hDEAD_0002);  // R10 just past range 0
    txn(32'h2000_FFFC, 4'b0110, 1, 4, 2, 32'h0F0F_F0F0);  // top of range 1
    txn(32'h1000_0000, 4'b0110, 0, 3, 0, 32'h7777_8888);  // base of range 0
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule